// File: doc/BRIEF.md
# Up/Down Binary Counter with Lookahead Output

This block is a binary counter whose width, counting direction, power-up value, reset value and lookahead distance are set by parameters. Every update happens on the rising clock edge and only while the clock enable is high. On an enabled edge the block takes one of four named operations. The operations, from highest priority down, are: RESET (load the reset value), LOAD (take the load data), STEP (advance by one in the configured direction) and HOLD (keep the value).

The count output comes straight from the state register, so a change is visible right after the edge that causes it. A combinational lookahead output shows the count advanced by a fixed number of steps in the counting direction, modulo 2^WIDTH. A single combinational wrap flag goes high when the coming edge will carry the count past the top while counting up, or past zero while counting down. Each move between operations is decided fresh on every edge from the control inputs, so no operation depends on an earlier one.

Top module: `updown_counter_la`

## Requirements
- R1: Before the first clock edge, `count` equals the INIT_VAL parameter, which may differ from RST_VAL.
- R2: An enabled edge with `rst` high loads RST_VAL, overriding both `load` and `cnt_en`.
- R3: With `clk_en` low, no edge changes `count`, whatever `rst`, `load` and `cnt_en` are doing.
- R4: An enabled edge with `rst` low and `load` high loads `load_val`, whether `cnt_en` is high or low.
- R5: An enabled edge with `rst` and `load` low and `cnt_en` high adds one (DIR = DIR_UP) or subtracts one (DIR = DIR_DOWN), modulo 2^WIDTH.
- R6: An enabled edge with `rst`, `load` and `cnt_en` all low leaves `count` unchanged.
- R7: `ahead` always equals `count` + AHEAD (up) or `count` − AHEAD (down), modulo 2^WIDTH.
- R8: `wrap` is high exactly when `clk_en` and `cnt_en` are high, `rst` and `load` are low, and `count` is all ones (up) or zero (down).
- R9: `count` shows the result of an enabled edge right after that edge, with no added cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge active |
| rst | input | 1 | Synchronous reset, active high, gated by clk_en |
| clk_en | input | 1 | Clock enable; gates every register update |
| cnt_en | input | 1 | Step request |
| load | input | 1 | Load request; outranks cnt_en |
| load_val | input | WIDTH | Data taken on a load |
| count | output | WIDTH | Current counter state |
| ahead | output | WIDTH | Count advanced by AHEAD steps in the counting direction |
| wrap | output | 1 | Next enabled step wraps the counter |

## Verification
The embedded assertions check on every cycle that a disabled clock freezes the count, that an enabled reset, load or step gives the value its operation requires on the next edge, that the lookahead moves with each step, and that a raised wrap flag is followed by the opposite end value. Only the bench's scenarios can show the power-up value before any edge, the clash between reset and load at the same edge, and full wrap runs in both directions. These scenarios are checked against a cycle-by-cycle reference model with non-default initial, reset and lookahead values.

// File: rtl/uc_pkg.sv
package uc_pkg;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_RESET = 2'd1,
        OP_LOAD  = 2'd2,
        OP_STEP  = 2'd3
    } op_e;

endpackage

// File: rtl/uc_ctrl.sv
module uc_ctrl
    import uc_pkg::*;
(
    input  logic clk_en,
    input  logic rst,
    input  logic load,
    input  logic cnt_en,
    output op_e  op
);

    always_comb begin
        if (!clk_en)     op = OP_HOLD;
        else if (rst)    op = OP_RESET;
        else if (load)   op = OP_LOAD;
        else if (cnt_en) op = OP_STEP;
        else             op = OP_HOLD;
    end

endmodule

// File: rtl/uc_next.sv
module uc_next
    import uc_pkg::*;
#(
    parameter int   WIDTH   = 4,
    parameter int   RST_VAL = 0,
    parameter dir_e DIR     = DIR_UP
) (
    input  op_e              op,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] load_val,
    output logic [WIDTH-1:0] nxt,
    output logic             at_end
);

    localparam logic [WIDTH-1:0] RST_W  = WIDTH'(RST_VAL);
    localparam logic [WIDTH-1:0] ONE_W  = WIDTH'(1);
    localparam logic [WIDTH-1:0] END_W  = (DIR == DIR_UP) ? {WIDTH{1'b1}} : '0;

    logic [WIDTH-1:0] stepped;

    generate
        if (DIR == DIR_UP) begin : g_up
            assign stepped = cur + ONE_W;
        end else begin : g_down
            assign stepped = cur - ONE_W;
        end
    endgenerate

    assign at_end = (cur == END_W);

    always_comb begin
        unique case (op)
            OP_RESET: nxt = RST_W;
            OP_LOAD:  nxt = load_val;
            OP_STEP:  nxt = stepped;
            OP_HOLD:  nxt = cur;
            default:  nxt = cur;
        endcase
    end

endmodule

// File: rtl/uc_ahead.sv
module uc_ahead
    import uc_pkg::*;
#(
    parameter int   WIDTH = 4,
    parameter int   AHEAD = 0,
    parameter dir_e DIR   = DIR_UP
) (
    input  logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] ahead
);

    localparam logic [WIDTH-1:0] OFS_W = WIDTH'(AHEAD);

    generate
        if (DIR == DIR_UP) begin : g_up
            assign ahead = cur + OFS_W;
        end else begin : g_down
            assign ahead = cur - OFS_W;
        end
    endgenerate

endmodule

// File: rtl/updown_counter_la.sv
module updown_counter_la
    import uc_pkg::*;
#(
    parameter int   WIDTH    = 4,
    parameter int   INIT_VAL = 0,
    parameter int   RST_VAL  = 0,
    parameter dir_e DIR      = DIR_UP,
    parameter int   AHEAD    = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clk_en,
    input  logic             cnt_en,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    output logic [WIDTH-1:0] count,
    output logic [WIDTH-1:0] ahead,
    output logic             wrap
);

    localparam logic [WIDTH-1:0] INIT_W = WIDTH'(INIT_VAL);
    localparam logic [WIDTH-1:0] RST_W  = WIDTH'(RST_VAL);
    localparam logic [WIDTH-1:0] ONE_W  = WIDTH'(1);
    localparam logic [WIDTH-1:0] OFS_W  = WIDTH'(AHEAD);
    localparam logic [WIDTH-1:0] WRAPPED_W = (DIR == DIR_UP) ? '0 : {WIDTH{1'b1}};

    op_e              op;
    logic [WIDTH-1:0] cnt_q = INIT_W;
    logic [WIDTH-1:0] cnt_d;
    logic             at_end;

    uc_ctrl u_ctrl (
        .clk_en (clk_en),
        .rst    (rst),
        .load   (load),
        .cnt_en (cnt_en),
        .op     (op)
    );

    uc_next #(
        .WIDTH   (WIDTH),
        .RST_VAL (RST_VAL),
        .DIR     (DIR)
    ) u_next (
        .op       (op),
        .cur      (cnt_q),
        .load_val (load_val),
        .nxt      (cnt_d),
        .at_end   (at_end)
    );

    uc_ahead #(
        .WIDTH (WIDTH),
        .AHEAD (AHEAD),
        .DIR   (DIR)
    ) u_ahead (
        .cur   (cnt_q),
        .ahead (ahead)
    );

    // State register; the output is taken from it directly (R9)
    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
    assign wrap  = (op == OP_STEP) && at_end;

    // R3: disabled clock freezes the count
    a_r3_hold_when_disabled: assert property (@(posedge clk)
        !clk_en |=> $stable(count));

    // R2: enabled reset loads the reset value on the next edge
    a_r2_reset_value: assert property (@(posedge clk)
        (clk_en && rst) |=> (count == RST_W));

    // R4: load outranks counting
    a_r4_load_value: assert property (@(posedge clk) disable iff (rst)
        (clk_en && load) |=> (count == $past(load_val)));

    // R6: idle enabled edge keeps the count
    a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (clk_en && !load && !cnt_en) |=> $stable(count));

    // R8: a raised wrap flag is followed by the opposite end value
    a_r8_wrap_end: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (count == WRAPPED_W));

    generate
        if (DIR == DIR_UP) begin : g_chk_up
            // R5: step up by one
            a_r5_step_up: assert property (@(posedge clk) disable iff (rst)
                (clk_en && !load && cnt_en) |=> (count == $past(count) + ONE_W));
            // R7: lookahead follows the step
            a_r7_ahead_up: assert property (@(posedge clk) disable iff (rst)
                (clk_en && !load && cnt_en) |=> (ahead == $past(ahead) + ONE_W));
            a_r7_ahead_ofs_up: assert property (@(posedge clk)
                (ahead - count) == OFS_W);
        end else begin : g_chk_down
            // R5: step down by one
            a_r5_step_down: assert property (@(posedge clk) disable iff (rst)
                (clk_en && !load && cnt_en) |=> (count == $past(count) - ONE_W));
            // R7: lookahead follows the step
            a_r7_ahead_down: assert property (@(posedge clk) disable iff (rst)
                (clk_en && !load && cnt_en) |=> (ahead == $past(ahead) - ONE_W));
            a_r7_ahead_ofs_down: assert property (@(posedge clk)
                (count - ahead) == OFS_W);
        end
    endgenerate

endmodule

// File: tb/sim_updown_counter_la.sv
module sim_updown_counter_la;
    import uc_pkg::*;

    localparam int W = 4;
    localparam logic [W-1:0] INIT0 = 4'd5,  RST0 = 4'd9,  AH0 = 4'd3;
    localparam logic [W-1:0] INIT1 = 4'd2,  RST1 = 4'd12, AH1 = 4'd5;

    logic clk = 1'b0;
    logic rst = 1'b0, clk_en = 1'b0, cnt_en = 1'b0, load = 1'b0;
    logic [W-1:0] load_val = '0;
    logic [W-1:0] count0, ahead0, count1, ahead1;
    logic wrap0, wrap1;

    logic [W-1:0] m0, m1;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    updown_counter_la #(.WIDTH(W), .INIT_VAL(5), .RST_VAL(9), .DIR(DIR_UP), .AHEAD(3)) u0 (
        .clk(clk), .rst(rst), .clk_en(clk_en), .cnt_en(cnt_en), .load(load),
        .load_val(load_val), .count(count0), .ahead(ahead0), .wrap(wrap0));

    updown_counter_la #(.WIDTH(W), .INIT_VAL(2), .RST_VAL(12), .DIR(DIR_DOWN), .AHEAD(5)) u1 (
        .clk(clk), .rst(rst), .clk_en(clk_en), .cnt_en(cnt_en), .load(load),
        .load_val(load_val), .count(count1), .ahead(ahead1), .wrap(wrap1));

    task automatic check(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [W-1:0] model(logic [W-1:0] cur, logic down, logic [W-1:0] rv);
        if (!clk_en)     return cur;
        if (rst)         return rv;
        if (load)        return load_val;
        if (cnt_en)      return down ? cur - 4'd1 : cur + 4'd1;
        return cur;
    endfunction

    // One cycle: drive inputs, check combinational outputs, clock, check count
    task automatic cyc(logic r, logic ce, logic ce_cnt, logic ld, logic [W-1:0] lv, string req);
        logic ew0, ew1;
        rst = r; clk_en = ce; cnt_en = ce_cnt; load = ld; load_val = lv;
        #1;
        ew0 = ce && !r && !ld && ce_cnt && (m0 == 4'hF);
        ew1 = ce && !r && !ld && ce_cnt && (m1 == 4'h0);
        check("R8", "wrap up", {3'b0, wrap0}, {3'b0, ew0});
        check("R8", "wrap down", {3'b0, wrap1}, {3'b0, ew1});
        check("R7", "ahead up", ahead0, m0 + AH0);
        check("R7", "ahead down", ahead1, m1 - AH1);
        m0 = model(m0, 1'b0, RST0);
        m1 = model(m1, 1'b1, RST1);
        @(posedge clk);
        #1;
        check(req, "count up", count0, m0);
        check(req, "count down", count1, m1);
    endtask

    task automatic t_power_up();
        #1;
        m0 = INIT0; m1 = INIT1;
        check("R1", "init up", count0, INIT0);
        check("R1", "init down", count1, INIT1);
    endtask

    task automatic t_disabled();
        cyc(1'b1, 1'b0, 1'b1, 1'b1, 4'd7, "R3");
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 4'd0, "R3");
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 4'd3, "R3");
    endtask

    task automatic t_reset();
        cyc(1'b1, 1'b1, 1'b1, 1'b1, 4'd7, "R2");
        check("R2", "reset up", count0, RST0);
        check("R2", "reset down", count1, RST1);
    endtask

    task automatic t_count_run();
        for (int i = 0; i < 20; i++) cyc(1'b0, 1'b1, 1'b1, 1'b0, 4'd0, "R5");
    endtask

    task automatic t_idle();
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 4'd11, "R6");
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 4'd4, "R6");
    endtask

    task automatic t_load();
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 4'd14, "R4");
        check("R9", "load visible up", count0, 4'd14);
        check("R9", "load visible down", count1, 4'd14);
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 4'd1, "R4");
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 4'd0, "R9");
    endtask

    task automatic t_wrap_edges();
        // up wraps from 15 to 0; down wraps from 0 to 15
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 4'd15, "R4");
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 4'd0, "R5");
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 4'd0, "R4");
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 4'd0, "R5");
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 4'd15, "R8");
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 4'd0, "R8");
    endtask

    initial begin
        t_power_up();
        t_disabled();
        t_reset();
        t_count_run();
        t_idle();
        t_load();
        t_wrap_edges();
        t_reset();
        t_count_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule